// File: doc/BRIEF.md
# Memory CRC Scan Controller

This block checks that a region of program memory is intact. Software writes a control register to start a scan. The block then reads one byte per clock from address 0 up to a fixed last address and feeds every byte into a CRC-16 engine. The region holds its own checksum in its last two bytes, high byte first. A region that is intact therefore leaves a remainder of zero. When the scan ends, the block reports pass or fail in a status register. If the non-maskable interrupt option is armed, a failure also raises the `nmi` output.

Three registers sit behind a small select-based port. Writes are sampled on the clock edge, and reads are combinational. The control word has three bits:
- a start bit, which stays set after a scan;
- a sticky interrupt-arm bit;
- a self-clearing clear strobe, which wipes the register state one cycle after it is written.

Which writes the block accepts depends on whether a scan is running, whether the interrupt is armed, and whether an interrupt has already fired. Memory is reached through a plain read port whose data is valid in the same cycle as the address.

Top module: `crc_scan_ctrl`

## Requirements
- R1: After system reset, every register reads 0x00 and `nmi` is low.
- R2: The control word sits at select 0. Bit 0 is the start bit and bit 1 is the interrupt-arm bit. Bit 7 is the clear strobe. Bits 7..2 always read 0.
- R3: Writing control bit 0 = 1 starts a scan. Status bit 0 (busy) reads 1 from the next cycle, for exactly LAST_ADDR+1 cycles. During those cycles, `mem_addr` steps 0,1,..,LAST_ADDR, one byte per cycle, with `mem_rd` high. The start bit still reads 1 after the scan ends.
- R4: Writing control bit 0 = 1 during a scan restarts the scan from address 0, with a full LAST_ADDR+1 busy window. Writing bit 0 = 0 changes nothing.
- R5: The CRC runs MSB first with polynomial 0x1021 and seed 0xFFFF. Status bit 1 (ok) is set when a finished scan leaves a remainder of 0. It is cleared at each start, and it stays 0 when the remainder is nonzero.
- R6: When the arm bit is 0, a clear strobe is accepted at any time. One cycle after the write, the clear takes effect: the start bit, the auxiliary register and the status register go to 0, and any running scan stops. The strobe never clears the arm bit.
- R7: When the arm bit is 1, a clear strobe written during a scan is ignored.
- R8: The arm bit can be set only while busy is 0. Once set, only system reset clears it.
- R9: A scan that finishes with a nonzero remainder while the arm bit is 1 raises `nmi`, which then stays high until system reset. When the arm bit is 0, `nmi` stays low.
- R10: While `nmi` is high, every write to the control word is ignored.
- R11: The auxiliary register at select 1 stores bits 1..0 of a write. The status register at select 2 is read-only. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for a read |
| rd_data | output | 8 | Read data (combinational) |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd | output | 1 | Memory read enable, high while scanning |
| mem_data | input | 8 | Memory byte at `mem_addr`, same cycle |
| nmi | output | 1 | Non-maskable interrupt request, sticky |

## Verification
The bench counts the busy window when a scan restarts partway through. A design that resumes from the old address, or that raises the done signal for the abandoned scan, gives a window shorter than LAST_ADDR+1. The bench also checks that the clear takes effect exactly one cycle late, and that the arm bit survives the clear. It then tries a clear strobe during a scan with the arm bit set, and tries to set the arm bit while busy. A design that ignores these gating rules either stops the scan or arms the interrupt. Finally, once `nmi` has fired, the bench tries to start a scan and to clear the control word. A design that leaves the control word unfrozen shows busy again or loses the start bit.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned CRC_W     = 16;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // bit positions inside the control and status words
  localparam int unsigned CTL_START_BIT = 0;
  localparam int unsigned CTL_ARM_BIT   = 1;
  localparam int unsigned CTL_CLR_BIT   = 7;
  localparam int unsigned ST_BUSY_BIT   = 0;
  localparam int unsigned ST_OK_BIT     = 1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_AUX  = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_NONE = 2'd3
  } reg_sel_e;

  // one byte into the CRC, MSB first
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] cur,
                                                  input logic [7:0] data);
    logic [CRC_W-1:0] r;
    r = cur ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_scan_engine.sv
module crc_scan_engine
  import crc_scan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LAST_ADDR = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [7:0]        mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;
  logic              busy_q;
  logic              at_last;

  assign crc_nxt    = crc16_byte(crc_q, mem_data_i);
  assign at_last    = (addr_q == LAST_A);
  assign mem_addr_o = addr_q;
  assign mem_rd_o   = busy_q;
  assign busy_o     = busy_q;
  // a restart or an abort in the last cycle discards the result
  assign done_o     = busy_q && at_last && !abort_i && !start_i;
  assign pass_o     = (crc_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      crc_q  <= CRC_SEED;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      addr_q <= '0;
      crc_q  <= CRC_SEED;
    end else if (busy_q) begin
      crc_q <= crc_nxt;
      if (at_last) busy_q <= 1'b0;
      else         addr_q <= addr_q + 1'b1;
    end
  end

endmodule

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
  import crc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             pass_i,
  output logic             start_o,
  output logic             clear_o,
  output logic             nmi_o,
  output logic             enable_o,
  output logic             arm_o,
  output logic             ok_o
);

  logic       enable_q, arm_q, ok_q, nmi_q, clr_q;
  logic [1:0] aux_q;
  logic       ctrl_wr, clr_req, arm_set, aux_wr;

  // the control word is frozen once an interrupt has fired
  assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == RSEL_CTRL) && !nmi_q;
  assign clr_req = ctrl_wr && wr_data[CTL_CLR_BIT] && (!arm_q || !busy_i);
  assign arm_set = ctrl_wr && wr_data[CTL_ARM_BIT] && !busy_i;
  assign start_o = ctrl_wr && wr_data[CTL_START_BIT] && !clr_req && !clr_q;
  assign aux_wr  = wr_en && (reg_sel_e'(wr_sel) == RSEL_AUX);
  assign clear_o = clr_q;
  assign nmi_o   = nmi_q;
  assign enable_o = enable_q;
  assign arm_o   = arm_q;
  assign ok_o    = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      arm_q    <= 1'b0;
      ok_q     <= 1'b0;
      nmi_q    <= 1'b0;
      clr_q    <= 1'b0;
      aux_q    <= '0;
    end else begin
      clr_q <= clr_req;
      if (arm_set) arm_q <= 1'b1;
      if (done_i && !pass_i && arm_q) nmi_q <= 1'b1;
      if (clr_q) begin
        enable_q <= 1'b0;
        ok_q     <= 1'b0;
        aux_q    <= '0;
      end else begin
        if (aux_wr) aux_q <= wr_data[1:0];
        if (start_o) begin
          enable_q <= 1'b1;
          ok_q     <= 1'b0;
        end else if (done_i) begin
          ok_q <= pass_i;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      RSEL_CTRL: begin
        rd_data[CTL_START_BIT] = enable_q;
        rd_data[CTL_ARM_BIT]   = arm_q;
      end
      RSEL_AUX:  rd_data[1:0] = aux_q;
      RSEL_STAT: begin
        rd_data[ST_BUSY_BIT] = busy_i;
        rd_data[ST_OK_BIT]   = ok_q;
      end
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
  import crc_scan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LAST_ADDR = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_sel,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_data,
  output logic              nmi
);

  // named internal events, observed by the bound checker
  logic start_w, clear_w, done_w, pass_w, busy_w;
  logic enable_w, arm_w, ok_w;

  crc_scan_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .busy_i   (busy_w),
    .done_i   (done_w),
    .pass_i   (pass_w),
    .start_o  (start_w),
    .clear_o  (clear_w),
    .nmi_o    (nmi),
    .enable_o (enable_w),
    .arm_o    (arm_w),
    .ok_o     (ok_w)
  );

  crc_scan_engine #(
    .ADDR_W    (ADDR_W),
    .LAST_ADDR (LAST_ADDR)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_w),
    .abort_i    (clear_w),
    .mem_data_i (mem_data),
    .mem_addr_o (mem_addr),
    .mem_rd_o   (mem_rd),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .pass_o     (pass_w)
  );

endmodule

// File: rtl/crc_scan_chk.sv
module crc_scan_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LAST_ADDR = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [7:0]        wr_data,
  input logic [1:0]        rd_sel,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              nmi,
  input logic              busy,
  input logic              start,
  input logic              clear,
  input logic              enable,
  input logic              arm,
  input logic              ok
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
  localparam logic [ADDR_W:0]   SPAN   = (ADDR_W+1)'(LAST_ADDR);

  logic [ADDR_W:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (start || !busy)  run_cnt <= '0;
    else                      run_cnt <= run_cnt + 1'b1;
  end

  // R2
  ctrl_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> (rd_data[7:2] == 6'd0));

  // R3
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= SPAN));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !clear && mem_addr != LAST_A) |=> (mem_addr == $past(mem_addr) + 1'b1));

  // R6
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!enable && !busy && !ok));

  // R7
  armed_clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[7] && arm && busy) |=> !clear);

  // R8
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> arm);

  // R8
  arm_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |-> !$past(busy));

  // R9
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> nmi);

  // R9
  nmi_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> arm);

  // R10
  frozen_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> (!start && !clear));

endmodule

bind crc_scan_ctrl crc_scan_chk #(
  .ADDR_W    (ADDR_W),
  .LAST_ADDR (LAST_ADDR)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .mem_addr (mem_addr),
  .nmi      (nmi),
  .busy     (busy_w),
  .start    (start_w),
  .clear    (clear_w),
  .enable   (enable_w),
  .arm      (arm_w),
  .ok       (ok_w)
);

// File: tb/crc_scan_ctrl_tb_top.sv
module crc_scan_ctrl_tb_top;

  localparam int ADDR_W = 8;
  localparam int LAST   = 63;
  localparam int NB     = LAST + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = 2'd0;
  logic [7:0]        wr_data = 8'd0;
  logic [1:0]        rd_sel = 2'd0;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd;
  logic [7:0]        mem_data;
  logic              nmi;
  logic [7:0]        mem [0:NB-1];

  assign mem_data = mem[mem_addr[5:0]];

  crc_scan_ctrl #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .nmi(nmi)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bit-serial CRC, data bit folded into the feedback
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // behavioural reference state
  int m_en, m_arm, m_busy, m_ok, m_nmi, m_aux, m_pend, m_addr, m_live;
  logic [15:0] m_crc;

  always @(posedge clk) begin : model
    int cw, rq, setn, st, dn;
    logic [15:0] nc;
    if (!rst_n) begin
      m_en = 0; m_arm = 0; m_busy = 0; m_ok = 0; m_nmi = 0; m_aux = 0;
      m_pend = 0; m_addr = 0; m_crc = 16'hFFFF; m_live = 1;
    end else begin
      cw   = (wr_en && wr_sel == 2'd0 && m_nmi == 0);
      rq   = (cw && wr_data[7] && (m_arm == 0 || m_busy == 0));
      setn = (cw && wr_data[1] && m_busy == 0);
      st   = (cw && wr_data[0] && !rq && m_pend == 0);
      nc   = ref_crc(m_crc, mem[m_addr]);
      dn   = (m_busy && !m_pend && !st && m_addr == LAST);
      if (dn && nc != 16'h0 && m_arm) m_nmi = 1;
      if (setn) m_arm = 1;
      if (m_pend) begin
        m_en = 0; m_aux = 0; m_ok = 0; m_busy = 0;
      end else begin
        if (wr_en && wr_sel == 2'd1) m_aux = int'(wr_data[1:0]);
        if (st) begin
          m_en = 1; m_busy = 1; m_ok = 0; m_addr = 0; m_crc = 16'hFFFF;
        end else if (m_busy) begin
          m_crc = nc;
          if (m_addr == LAST) begin m_busy = 0; m_ok = (nc == 16'h0); end
          else m_addr = m_addr + 1;
        end
      end
      m_pend = rq;
    end
  end

  // compare against the reference every cycle
  always @(negedge clk) begin
    int exp;
    if (rst_n && m_live == 1 && !finished) begin
      case (rd_sel)
        2'd0: exp = m_arm * 2 + m_en;
        2'd1: exp = m_aux;
        2'd2: exp = m_ok * 2 + m_busy;
        default: exp = 0;
      endcase
      chk(rd_data == exp[7:0], "R11", "cycle readback", rd_data, exp);
      chk(nmi == m_nmi[0], "R9", "cycle nmi", nmi, m_nmi);
      chk(mem_rd == m_busy[0], "R3", "cycle mem_rd", mem_rd, m_busy);
      if (m_busy) chk(mem_addr == m_addr[7:0], "R3", "cycle mem_addr", mem_addr, m_addr);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic rdchk(input logic [1:0] sel, input int exp, input string req, input string what);
    rd_sel = sel; #1;
    chk(rd_data == exp[7:0], req, what, rd_data, exp);
  endtask

  task automatic fill_good();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < NB; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    for (int i = 0; i < NB - 2; i++) c = ref_crc(c, mem[i]);
    mem[NB-2] = c[15:8];
    mem[NB-1] = c[7:0];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    fill_good();
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdchk(2'd0, 0, "R1", "ctrl after reset");
    rdchk(2'd1, 0, "R1", "aux after reset");
    rdchk(2'd2, 0, "R1", "status after reset");
    chk(nmi == 1'b0, "R1", "nmi after reset", nmi, 0);

    // R3 / R5 good scan
    rd_sel = 2'd2;
    wr(2'd0, 8'h01);
    rdchk(2'd2, 1, "R3", "busy after start");
    idle(NB + 2);
    rdchk(2'd2, 2, "R5", "ok after good scan");
    rdchk(2'd0, 1, "R3", "start bit stays set");
    // R4 write of zero
    wr(2'd0, 8'h00);
    rdchk(2'd0, 1, "R4", "zero write no effect");
    // R11 aux and read-only status
    wr(2'd1, 8'hFF);
    rdchk(2'd1, 3, "R11", "aux stores two bits");
    wr(2'd2, 8'hFF);
    rdchk(2'd2, 2, "R11", "status read-only");
    rdchk(2'd3, 0, "R11", "select 3 reads zero");

    // R4 restart mid-scan
    wr(2'd0, 8'h01);
    idle(10);
    wr(2'd0, 8'h01);
    rd_sel = 2'd2; #1;
    cnt = 0;
    while (rd_data[0] && cnt < 4 * NB) begin cnt++; idle(1); rd_sel = 2'd2; #1; end
    chk(cnt == NB, "R4", "restart busy window", cnt, NB);
    rdchk(2'd2, 2, "R5", "ok after restart");

    // R5 bad data, arm off
    mem[5] = mem[5] ^ 8'h01;
    wr(2'd0, 8'h01);
    idle(NB + 2);
    rdchk(2'd2, 0, "R5", "ok clear on bad crc");
    chk(nmi == 1'b0, "R9", "no nmi when not armed", nmi, 0);
    mem[5] = mem[5] ^ 8'h01;

    // R6 clear strobe during a scan, arm off
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h01);
    idle(5);
    wr(2'd0, 8'h80);
    rdchk(2'd2, 1, "R6", "busy still set in strobe cycle");
    idle(1);
    rdchk(2'd2, 0, "R6", "status cleared");
    rdchk(2'd0, 0, "R6", "ctrl cleared, strobe reads 0");
    rdchk(2'd1, 0, "R6", "aux cleared");

    // R8 arm only when idle
    wr(2'd0, 8'h01);
    idle(3);
    wr(2'd0, 8'h02);
    rdchk(2'd0, 1, "R8", "arm ignored while busy");
    idle(NB + 2);
    wr(2'd0, 8'h02);
    rdchk(2'd0, 3, "R8", "arm set when idle");
    wr(2'd0, 8'h80);
    idle(1);
    rdchk(2'd0, 2, "R8", "arm survives clear strobe");

    // R7 clear blocked while busy and armed
    wr(2'd0, 8'h01);
    idle(3);
    wr(2'd0, 8'h80);
    idle(2);
    rdchk(2'd2, 1, "R7", "scan keeps running");
    rdchk(2'd0, 3, "R7", "ctrl unchanged");
    idle(NB + 2);
    chk(nmi == 1'b0, "R9", "no nmi on good scan", nmi, 0);

    // R9 armed failure
    mem[20] = mem[20] ^ 8'h40;
    wr(2'd0, 8'h01);
    idle(NB + 2);
    chk(nmi == 1'b1, "R9", "nmi on armed failure", nmi, 1);
    // R10 frozen control
    wr(2'd0, 8'h01);
    idle(1);
    rdchk(2'd2, 0, "R10", "start ignored after nmi");
    wr(2'd0, 8'h80);
    idle(2);
    rdchk(2'd0, 3, "R10", "clear ignored after nmi");
    chk(nmi == 1'b1, "R9", "nmi sticky", nmi, 1);

    // R8 / R9 system reset clears arm and nmi
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rdchk(2'd0, 0, "R8", "arm cleared by system reset");
    chk(nmi == 1'b0, "R9", "nmi cleared by system reset", nmi, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule